// File: doc/BRIEF.md
# Redundant-Operand Multiplier

This block multiplies a value that is still held as two unsigned addends by a plain binary operand, so a product of a sum, (X + Y) * Z, is formed without first adding X and Y with a carry chain. The two addends arrive as a pair of equally weighted N-bit vectors, which is the usual output of an upstream compressor stage. Z is an M-bit unsigned binary value.

Inside, a single row of half-adders turns the redundant pair into one sum bit and one delayed-carry bit per position. The sum bit at position i and the delayed carry that leaves that same half-adder can never both be 1. Because of this, the two partial-product bits that land on the same weight from neighbouring multiplier bits are merged with one OR gate, which leaves M+1 rows instead of 2M. A chain of full-adder rows reduces those rows to two, and a final carry-propagate addition gives the binary product. The result is registered once and is flagged by a valid strobe one cycle after the operands are accepted.

Top module: `csm_top`

## Requirements
- R1: While rstN is low, and on the first cycle after it rises, outValid is 0 and product is 0.
- R2: When inValid is high at a rising clock edge, product after that edge equals (sumVec + carryVec) * multVec. All three are unsigned, and sumVec and carryVec carry the same bit weights.
- R3: outValid is high after a rising edge exactly when inValid was high at that edge.
- R4: When inValid is low at a rising edge, product keeps its previous value, whatever the other inputs do.
- R5: With sumVec and carryVec all ones and multVec all ones, product is the full (2^(N+1) - 2) * (2^M - 1), with no bit lost in the N+M+1-bit output.
- R6: A multVec of zero gives a product of zero for any redundant pair.
- R7: A carryVec of zero gives product = sumVec * multVec.
- R8: Operands presented on every cycle, back to back, each give their own correct product one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands on the inputs are to be multiplied this cycle |
| sumVec | input | N | First vector of the redundant multiplicand |
| carryVec | input | N | Second vector of the redundant multiplicand, same weights as sumVec |
| multVec | input | M | Binary multiplier operand |
| outValid | output | 1 | product holds a new result |
| product | output | N+M+1 | Registered unsigned product |

## Verification
The bench drives both vectors all ones. There every half-adder produces a delayed carry, and a design that wrongly ORed non-exclusive bits, or that dropped the top column, would lose the most significant product bits. Zero carry vectors and zero multipliers check that the merge does not invent bits. Idle cycles with changing inputs catch a result register that reloads without a strobe. Back-to-back operands catch a valid flag or result that trails by a cycle or mixes neighbouring operands.

// File: rtl/csm_pkg.sv
package csm_pkg;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic capture;   // load the freshly computed product into the result register
  } csmStrobe_t;

endpackage

// File: rtl/csm_recode.sv
// Half-adder row plus OR-merged partial-product generation.
module csm_recode #(
  parameter int N = 8,
  parameter int M = 8
) (
  input  logic [N-1:0]        sumVec,
  input  logic [N-1:0]        carryVec,
  input  logic [M-1:0]        multVec,
  output logic [M:0][N-1:0]   rows
);

  logic [N-1:0] xBit;      // half-adder sum, weight i
  logic [N:1]   yBit;      // half-adder delayed carry, weight i
  logic [M+1:0] multPad;   // multPad[j+1] == multVec[j], zero at both ends

  for (genvar i = 0; i < N; i++) begin : g_halfAdd
    assign xBit[i]   = sumVec[i] ^ carryVec[i];
    assign yBit[i+1] = sumVec[i] & carryVec[i];
  end

  assign multPad = {1'b0, multVec, 1'b0};

  // Row j, bit i sits at weight i+j. It combines xBit[i]*mult[j] with
  // yBit[i+1]*mult[j-1]; both come from the same half-adder and are exclusive.
  always_comb begin
    for (int j = 0; j <= M; j++) begin
      for (int i = 0; i < N; i++) begin
        rows[j][i] = (xBit[i] & multPad[j+1]) | (yBit[i+1] & multPad[j]);
      end
    end
  end

endmodule

// File: rtl/csm_csa_row.sv
// One row of full adders: three vectors in, sum and shifted carry out.
module csm_csa_row #(
  parameter int W = 17
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);

  assign sumOut   = inA ^ inB ^ inC;
  assign carryOut = {(inA[W-2:0] & inB[W-2:0]) |
                     (inA[W-2:0] & inC[W-2:0]) |
                     (inB[W-2:0] & inC[W-2:0]), 1'b0};

endmodule

// File: rtl/csm_reduce.sv
// Reduces the M+1 merged rows to a sum/carry pair.
module csm_reduce #(
  parameter int N = 8,
  parameter int M = 8,
  localparam int P = N + M + 1
) (
  input  logic [M:0][N-1:0] rows,
  output logic [P-1:0]      redSum,
  output logic [P-1:0]      redCarry
);

  logic [P-1:0] aligned [0:M];
  logic [P-1:0] accS    [0:M-1];
  logic [P-1:0] accC    [0:M-1];

  always_comb begin
    for (int j = 0; j <= M; j++) begin
      aligned[j] = P'(rows[j]) << j;
    end
  end

  assign accS[0] = aligned[0];
  assign accC[0] = aligned[1];

  for (genvar k = 1; k < M; k++) begin : g_stage
    csm_csa_row #(.W(P)) u_row (
      .inA     (accS[k-1]),
      .inB     (accC[k-1]),
      .inC     (aligned[k+1]),
      .sumOut  (accS[k]),
      .carryOut(accC[k])
    );
  end

  assign redSum   = accS[M-1];
  assign redCarry = accC[M-1];

endmodule

// File: rtl/csm_datapath.sv
module csm_datapath
  import csm_pkg::*;
#(
  parameter int N = 8,
  parameter int M = 8,
  localparam int P = N + M + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  csmStrobe_t    strobe,
  input  logic [N-1:0]  sumVec,
  input  logic [N-1:0]  carryVec,
  input  logic [M-1:0]  multVec,
  output logic [P-1:0]  product
);

  logic [M:0][N-1:0] rows;
  logic [P-1:0]      redSum;
  logic [P-1:0]      redCarry;
  logic [P-1:0]      binProduct;

  csm_recode #(.N(N), .M(M)) u_recode (
    .sumVec  (sumVec),
    .carryVec(carryVec),
    .multVec (multVec),
    .rows    (rows)
  );

  csm_reduce #(.N(N), .M(M)) u_reduce (
    .rows    (rows),
    .redSum  (redSum),
    .redCarry(redCarry)
  );

  // Final carry-propagate step; the adder architecture is left to synthesis.
  assign binProduct = redSum + redCarry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product <= '0;
    end else if (strobe.capture) begin
      product <= binProduct;
    end
  end

endmodule

// File: rtl/csm_ctrl.sv
module csm_ctrl
  import csm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output csmStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe.capture = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

endmodule

// File: rtl/csm_top.sv
module csm_top
  import csm_pkg::*;
#(
  parameter int N = 8,
  parameter int M = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [N-1:0]   sumVec,
  input  logic [N-1:0]   carryVec,
  input  logic [M-1:0]   multVec,
  output logic           outValid,
  output logic [N+M:0]   product
);

  csmStrobe_t strobe;

  csm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  csm_datapath #(.N(N), .M(M)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sumVec  (sumVec),
    .carryVec(carryVec),
    .multVec (multVec),
    .product (product)
  );

endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
  parameter int N = 8,
  parameter int M = 8,
  localparam int P = N + M + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [N-1:0]  sumVec,
  input logic [N-1:0]  carryVec,
  input logic [M-1:0]  multVec,
  input logic          outValid,
  input logic [P-1:0]  product
);

  AST_PRODUCT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> product == (P'($past(sumVec)) + P'($past(carryVec))) * P'($past(multVec))); // R2

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R3

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R3

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(product)); // R4

  AST_ZERO_MULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && multVec == '0) |=> product == '0); // R6

  AST_ZERO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && carryVec == '0) |=> product == P'($past(sumVec)) * P'($past(multVec))); // R7

endmodule

bind csm_top csm_checker #(.N(N), .M(M)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .sumVec  (sumVec),
  .carryVec(carryVec),
  .multVec (multVec),
  .outValid(outValid),
  .product (product)
);

// File: tb/sim_csm_top.sv
`timescale 1ns/1ps
module sim_csm_top;

  localparam int N = 8;
  localparam int M = 8;
  localparam int P = N + M + 1;
  localparam longint SMASK = (64'd1 << N) - 1;
  localparam longint MMASK = (64'd1 << M) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [N-1:0]  sumVec = '0;
  logic [N-1:0]  carryVec = '0;
  logic [M-1:0]  multVec = '0;
  logic          outValid;
  logic [P-1:0]  product;

  int checks = 0;
  int errors = 0;
  bit checkEn = 1'b0;
  bit done = 1'b0;
  string phaseTag = "R2";

  // Reference model state, updated on every rising edge.
  bit     expValid = 1'b0;
  longint expProd = 0;
  string  expTag = "R1";

  always #5 clk = ~clk;

  csm_top #(.N(N), .M(M)) u0 (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .sumVec  (sumVec),
    .carryVec(carryVec),
    .multVec (multVec),
    .outValid(outValid),
    .product (product)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expProd  <= 0;
      expTag   <= "R1";
    end else begin
      expValid <= inValid;
      if (inValid) begin
        expProd <= (longint'(sumVec) + longint'(carryVec)) * longint'(multVec);
        expTag  <= phaseTag;
      end else begin
        expTag  <= "R4";
      end
    end
  end

  always @(negedge clk) begin
    if (checkEn && !done) begin
      checks++;
      if (outValid !== expValid) begin
        errors++;
        $display("FAIL %s outValid actual %0b expected %0b", (expTag == "R1") ? "R1" : "R3",
                 outValid, expValid);
      end
      checks++;
      if (longint'(product) !== expProd) begin
        errors++;
        $display("FAIL %s product actual %0d expected %0d", expTag, product, expProd);
      end
    end
  end

  task automatic drive(input bit v, input longint s, input longint c, input longint m);
    @(negedge clk);
    inValid  = v;
    sumVec   = N'(s & SMASK);
    carryVec = N'(c & SMASK);
    multVec  = M'(m & MMASK);
  endtask

  function automatic longint rnd();
    return longint'($urandom);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    // R1: reset state
    @(posedge clk);
    @(negedge clk);
    checkEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    drive(1'b0, 0, 0, 0);

    // R2: random operands with random gaps
    phaseTag = "R2";
    for (int n = 0; n < 60; n++) begin
      drive(($urandom % 3) != 0, rnd(), rnd(), rnd());
    end

    // R8: back to back every cycle
    phaseTag = "R8";
    for (int n = 0; n < 40; n++) begin
      drive(1'b1, rnd(), rnd(), rnd());
    end

    // R5: all-ones corners
    phaseTag = "R5";
    drive(1'b1, SMASK, SMASK, MMASK);
    drive(1'b1, SMASK, SMASK, 1);
    drive(1'b1, SMASK, 0, MMASK);
    drive(1'b1, 0, SMASK, MMASK);
    for (int n = 0; n < 10; n++) begin
      drive(1'b1, SMASK, rnd(), rnd());
      drive(1'b1, rnd(), SMASK, MMASK);
    end

    // R6: zero multiplier
    phaseTag = "R6";
    for (int n = 0; n < 10; n++) begin
      drive(1'b1, rnd(), rnd(), 0);
    end
    drive(1'b1, SMASK, SMASK, 0);

    // R7: zero carry vector
    phaseTag = "R7";
    for (int n = 0; n < 10; n++) begin
      drive(1'b1, rnd(), 0, rnd());
    end

    // R4: idle cycles with changing operands must not disturb the result
    phaseTag = "R2";
    drive(1'b1, 77, 200, 143);
    for (int n = 0; n < 12; n++) begin
      drive(1'b0, rnd(), rnd(), rnd());
    end

    // R1: reset again in the middle of activity
    drive(1'b1, SMASK, SMASK, MMASK);
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    inValid = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule